// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block produces the word address for each beat of a four-beat burst. When a load strobe is seen on a rising clock edge, it stores the starting address. The address then steps through the other three words of the same aligned group of four, one step per clock edge on which the active-low advance input is held low.

Only the two low bits move. The bits above them keep the value that was loaded for the whole burst. A static order-select input picks one of two step orders:

- Linear wrap: the start offset plus the beat count, modulo four.
- Interleaved: the start offset XOR the beat count.

The block does not judge whether a load or an advance is legal; the controller above it makes that decision. It holds no memory array.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0.
- R2: On the edge after one on which load_i is high, addr_o equals the start_addr_i value sampled on that edge.
- R3: Bits [15:2] of addr_o change only on an edge on which load_i is high.
- R4: With order_sel_i high (interleaved), the low two bits of the burst after loading start offset s are s, s^1, s^2, s^3. From 00 this is 00,01,10,11; from 01 it is 01,00,11,10; from 10 it is 10,11,00,01; from 11 it is 11,10,01,00.
- R5: With order_sel_i low (linear), the low two bits run s, s+1, s+2, s+3 modulo 4. From 00 this is 00,01,10,11; from 01 it is 01,10,11,00; from 10 it is 10,11,00,01; from 11 it is 11,00,01,10.
- R6: On an edge on which load_i is low and adv_ni is high, addr_o is held, provided order_sel_i is unchanged.
- R7: A fourth advance after a load returns addr_o to the loaded start address.
- R8: When load_i is high and adv_ni is low on the same edge, the load wins and addr_o equals the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture start_addr_i and restart the beat count |
| start_addr_i | input | 16 | Starting word address |
| adv_ni | input | 1 | Advance one beat, active low |
| order_sel_i | input | 1 | 1 = interleaved order, 0 = linear order (static) |
| addr_o | output | 16 | Current word address |

## Verification
The hardest cases to reach from the ports are those where the burst state interacts with other events. One is a suspended cycle in the middle of a burst that must not disturb a later wrap back to the start. The other is a reload that lands in the same cycle as an advance.

Every start offset in both orders is driven through a full burst, with a held cycle inserted after the first step. A fourth advance then checks the wrap. A separate directed sequence loads a new address part-way through a burst while advance is asserted, then steps once from there.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int ADDR_W = 16;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2,
  localparam int HI_W  = ADDR_W - BEAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [HI_W-1:0]   base_o,
  output logic [BEAT_W-1:0] off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      off_o  <= '0;
    end else if (load_i) begin
      base_o <= start_addr_i[ADDR_W-1:BEAT_W];
      off_o  <= start_addr_i[BEAT_W-1:0];
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_ni,
  output logic [BEAT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (load_i)  cnt_o <= '0;     // load beats advance
    else if (!adv_ni) cnt_o <= cnt_o + BEAT_W'(1);
  end

  a_r8_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == '0);

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && cnt_o == '1) |=> cnt_o == '0);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order_i,
  input  logic [BEAT_W-1:0] off_i,
  input  logic [BEAT_W-1:0] cnt_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] xor_beat;
  logic [BEAT_W-1:0] lin_beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_beat[b] = off_i[b] ^ cnt_i[b];
  end

  assign lin_beat = off_i + cnt_i;   // wraps modulo group size
  assign beat_o   = (order_i == ORD_XOR) ? xor_beat : lin_beat;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = burst_pkg::ADDR_W,
  parameter int BEAT_W = burst_pkg::BEAT_W,
  localparam int HI_W  = ADDR_W - BEAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_ni,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [HI_W-1:0]   base;
  logic [BEAT_W-1:0] off;
  logic [BEAT_W-1:0] cnt;
  logic [BEAT_W-1:0] beat;
  burst_order_e      order;

  assign order = burst_order_e'(order_sel_i);

  burst_start_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_start (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .base_o       (base),
    .off_o        (off)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .adv_ni (adv_ni),
    .cnt_o  (cnt)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i (order),
    .off_i   (off),
    .cnt_i   (cnt),
    .beat_o  (beat)
  );

  assign addr_o = {base, beat};

  a_r2_load_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(start_addr_i));

  a_r3_upper_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  a_r6_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> ($stable(addr_o) || !$stable(order_sel_i)));

  a_r1_reset: assert property (@(posedge clk_i)
    !rst_ni |-> addr_o == '0);
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] start_addr_i = '0;
  logic        adv_ni = 1'b1;
  logic        order_sel_i = 1'b1;
  logic [15:0] addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  burst_addr_gen uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .start_addr_i (start_addr_i),
    .adv_ni       (adv_ni),
    .order_sel_i  (order_sel_i),
    .addr_o       (addr_o)
  );

  // {order, beat0, beat1, beat2, beat3}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 8'b00_01_10_11}, {1'b1, 8'b01_00_11_10},
    {1'b1, 8'b10_11_00_01}, {1'b1, 8'b11_10_01_00},
    {1'b0, 8'b00_01_10_11}, {1'b0, 8'b01_10_11_00},
    {1'b0, 8'b10_11_00_01}, {1'b0, 8'b11_00_01_10}
  };

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (addr_o !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [13:0] base;
    logic [15:0] st;

    tick();
    check("R1 reset", 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < 8; i++) begin
      base        = 14'h1A5 + 14'(i * 14'h0321);
      st          = {base, VEC[i][7:6]};
      order_sel_i = VEC[i][8];
      load_i = 1'b1; start_addr_i = st; adv_ni = 1'b1;
      tick();
      load_i = 1'b0; start_addr_i = 16'hFFFF;
      check("R2 load", st);
      for (int k = 1; k < 4; k++) begin
        adv_ni = 1'b0;
        tick();
        check(VEC[i][8] ? "R4 interleaved/R3" : "R5 linear/R3",
              {base, VEC[i][7-2*k -: 2]});
        if (k == 1) begin
          adv_ni = 1'b1;
          tick();
          check("R6 suspend", {base, VEC[i][5:4]});
        end
      end
      adv_ni = 1'b0;
      tick();
      check("R7 wrap", st);
      adv_ni = 1'b1;
    end

    // load during active advance mid-burst
    order_sel_i = 1'b0;
    load_i = 1'b1; start_addr_i = 16'hBEE1; adv_ni = 1'b1;
    tick();
    load_i = 1'b0; adv_ni = 1'b0;
    tick();
    check("R5 linear step", 16'hBEE2);
    load_i = 1'b1; start_addr_i = 16'h4443;
    tick();
    load_i = 1'b0;
    check("R8 load priority", 16'h4443);
    tick();
    check("R5 step after reload", 16'h4440);
    adv_ni = 1'b1;
    tick();
    check("R3 upper held", 16'h4440);

    // reset mid-burst
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", 16'h0000);
    tick();
    finish_run();
  end
endmodule